// File: doc/BRIEF.md
# Byte-Addressed Register File with Pointer Windows

This block is the data memory of a small 8-bit controller core. One 8-bit address selects a byte in a 256-location space. The upper part, from 30H to FFH, is 208 bytes of general-purpose RAM. The lower part, from 00H to 2FH, holds special-function locations: two pointer registers, a bank pointer, an accumulator, a status byte and a set of peripheral registers. Here the peripheral registers are plain storage. Any location in the lower part that is not backed by storage reads as zero.

Two addresses, 00H and 02H, have no storage of their own. They are windows: an access to 00H goes to the byte whose address sits in the first pointer (01H), and an access to 02H goes to the byte named by the second pointer (03H). A pointer that names one of the two windows gives a blocked access: a read returns 00H and a modification does nothing.

Each cycle the core presents an address and either a byte write or a single-bit set/clear with a bit index. Read data follows the address combinationally. A bit operation is a read-modify-write that completes at one clock edge. A bit operation follows the window redirection exactly as a byte write does.

Top module: `dmem_regfile`

## Requirements
- R1: Addresses 30H–FFH are general-purpose RAM: a byte written with `wr_en` at a rising edge is returned on `rdata` whenever that address is presented afterwards. `rdata` depends combinationally on `addr`.
- R2: Address 00H reads and modifies the location whose address is held at 01H, and address 02H does the same with the pointer at 03H. The target may be any location, including a pointer register.
- R3: When the selected pointer holds 00H or 02H, a window read returns 00H. A byte write or bit operation through that window changes no location.
- R4: Addresses 0FH–11H, 1FH, 20H and 24H–2FH are unused. They read 00H, and byte writes and bit operations to them change no location.
- R5: Locations 01H, 03H–0EH, 12H–1EH and 21H–23H are readable and writable 8-bit storage. Among them are the bank pointer (04H), the accumulator (05H) and the status byte (0AH).
- R6: With `bit_en` high, `bit_val` high and `wr_en` low, bit `bit_sel` (0 = LSB) of the resolved location becomes 1 at the edge. The other seven bits keep their values.
- R7: With `bit_en` high, `bit_val` low and `wr_en` low, bit `bit_sel` of the resolved location becomes 0. The other bits keep their values.
- R8: When `wr_en` and `bit_en` are both high, only the byte write takes effect.
- R9: Synchronous active-high `rst` clears every special-function location, including both pointers and the bank pointer, to 00H. General-purpose RAM keeps its contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Access address |
| wdata | input | 8 | Byte write data |
| wr_en | input | 1 | Byte write strobe |
| bit_en | input | 1 | Single-bit operation strobe |
| bit_val | input | 1 | 1 = set the bit, 0 = clear it |
| bit_sel | input | 3 | Bit index for the bit operation |
| rdata | output | 8 | Read data of the resolved location |

## Verification
On every cycle the checker module checks the following properties, all seen through the two pointer registers:
- unused addresses read zero;
- self-pointing windows read zero and do not modify the pointer;
- a window reads the other pointer when aimed at it;
- byte writes, bit sets and bit clears land on a pointer;
- write-over-bit priority holds;
- reset clears the pointers.

Properties on arbitrary RAM or peripheral bytes are left to the bench, which keeps a behavioural copy of all 256 locations and compares `rdata` every cycle. The bench scenarios cover RAM retention across reset, modification of a pointer through the opposite window, and random mixes of window and direct traffic.

// File: rtl/dmem_pkg.sv
`timescale 1ns/1ps
package dmem_pkg;
    localparam int unsigned AW    = 8;
    localparam int unsigned DW    = 8;
    localparam int unsigned BIT_W = $clog2(DW);

    typedef logic [AW-1:0]    addr_t;
    typedef logic [DW-1:0]    data_t;
    typedef logic [BIT_W-1:0] bit_t;

    localparam addr_t WIN0    = 8'h00;
    localparam addr_t PTR0    = 8'h01;
    localparam addr_t WIN1    = 8'h02;
    localparam addr_t PTR1    = 8'h03;
    localparam addr_t BANKP   = 8'h04;
    localparam addr_t ACCU    = 8'h05;
    localparam addr_t STAT    = 8'h0A;
    localparam addr_t GP_BASE = 8'h30;

    localparam int unsigned SFR_SPAN = int'(GP_BASE);
    localparam int unsigned GP_DEPTH = (1 << AW) - int'(GP_BASE);

    typedef enum logic [1:0] {
        OP_NONE,
        OP_WRITE,
        OP_BSET,
        OP_BCLR
    } op_e;

    typedef struct packed {
        addr_t ea;       // effective address after window redirection
        logic  via_ptr;  // access went through a window
        logic  blocked;  // window pointed at a window
    } res_t;

    function automatic logic is_window(addr_t a);
        return (a == WIN0) || (a == WIN1);
    endfunction

    function automatic logic in_gp(addr_t a);
        return a >= GP_BASE;
    endfunction

    function automatic logic sfr_present(addr_t a);
        return (a == PTR0)
            || (a >= PTR1  && a <= 8'h0E)
            || (a >= 8'h12 && a <= 8'h1E)
            || (a >= 8'h21 && a <= 8'h23);
    endfunction

    function automatic data_t apply_op(op_e op, data_t cur, data_t wd, bit_t b);
        case (op)
            OP_WRITE: return wd;
            OP_BSET:  return cur | (data_t'(1) << b);
            OP_BCLR:  return cur & ~(data_t'(1) << b);
            default:  return cur;
        endcase
    endfunction
endpackage

// File: rtl/dmem_resolve.sv
`timescale 1ns/1ps
module dmem_resolve
    import dmem_pkg::*;
(
    input  addr_t addr,
    input  data_t mp0,
    input  data_t mp1,
    output res_t  res
);
    always_comb begin
        res.via_ptr = is_window(addr);
        if (addr == WIN0)      res.ea = addr_t'(mp0);
        else if (addr == WIN1) res.ea = addr_t'(mp1);
        else                   res.ea = addr;
        res.blocked = res.via_ptr && is_window(res.ea);
    end
endmodule

// File: rtl/dmem_sfr_bank.sv
`timescale 1ns/1ps
module dmem_sfr_bank
    import dmem_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  addr_t waddr,
    input  data_t wdata,
    input  addr_t raddr,
    output data_t rdata,
    output data_t mp0,
    output data_t mp1
);
    data_t q [SFR_SPAN];

    for (genvar i = 0; i < SFR_SPAN; i++) begin : g_sfr
        if (sfr_present(addr_t'(i))) begin : g_reg
            data_t r;
            always_ff @(posedge clk) begin
                if (rst)                               r <= '0;
                else if (we && waddr == addr_t'(i))    r <= wdata;
            end
            assign q[i] = r;
        end else begin : g_none
            assign q[i] = '0;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < SFR_SPAN; i++) begin
            if (raddr == addr_t'(i)) rdata = q[i];
        end
    end

    assign mp0 = q[int'(PTR0)];
    assign mp1 = q[int'(PTR1)];
endmodule

// File: rtl/dmem_gp_ram.sv
`timescale 1ns/1ps
module dmem_gp_ram
    import dmem_pkg::*;
#(
    parameter int unsigned DEPTH = GP_DEPTH,
    parameter addr_t       BASE  = GP_BASE
) (
    input  logic  clk,
    input  logic  we,
    input  addr_t waddr,
    input  data_t wdata,
    input  addr_t raddr,
    output data_t rdata
);
    data_t mem [DEPTH];
    addr_t woff, roff;

    assign woff  = waddr - BASE;
    assign roff  = raddr - BASE;
    assign rdata = mem[roff];

    always_ff @(posedge clk) begin
        if (we) mem[woff] <= wdata;
    end
endmodule

// File: rtl/dmem_regfile.sv
`timescale 1ns/1ps
module dmem_regfile
    import dmem_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  addr,
    input  logic [7:0]  wdata,
    input  logic        wr_en,
    input  logic        bit_en,
    input  logic        bit_val,
    input  logic [2:0]  bit_sel,
    output logic [7:0]  rdata
);
    op_e   op;
    res_t  res;
    data_t mp0_q, mp1_q;
    data_t sfr_rd, gp_rd, cur, nxt;
    logic  commit, sfr_we, gp_we;

    // byte write takes priority over a bit operation
    always_comb begin
        if (wr_en)       op = OP_WRITE;
        else if (bit_en) op = bit_val ? OP_BSET : OP_BCLR;
        else             op = OP_NONE;
    end

    dmem_resolve u_res (
        .addr (addr),
        .mp0  (mp0_q),
        .mp1  (mp1_q),
        .res  (res)
    );

    dmem_sfr_bank u_sfr (
        .clk   (clk),
        .rst   (rst),
        .we    (sfr_we),
        .waddr (res.ea),
        .wdata (nxt),
        .raddr (res.ea),
        .rdata (sfr_rd),
        .mp0   (mp0_q),
        .mp1   (mp1_q)
    );

    dmem_gp_ram u_gp (
        .clk   (clk),
        .we    (gp_we),
        .waddr (res.ea),
        .wdata (nxt),
        .raddr (res.ea),
        .rdata (gp_rd)
    );

    always_comb begin
        if (res.blocked)        cur = '0;
        else if (in_gp(res.ea)) cur = gp_rd;
        else                    cur = sfr_rd;
    end

    assign nxt    = apply_op(op, cur, wdata, bit_sel);
    assign commit = (op != OP_NONE) && !res.blocked;
    assign sfr_we = commit && !in_gp(res.ea) && sfr_present(res.ea);
    assign gp_we  = commit && in_gp(res.ea);
    assign rdata  = cur;
endmodule

// File: rtl/dmem_regfile_chk.sv
`timescale 1ns/1ps
module dmem_regfile_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] addr,
    input logic [7:0] wdata,
    input logic       wr_en,
    input logic       bit_en,
    input logic       bit_val,
    input logic [2:0] bit_sel,
    input logic [7:0] rdata,
    input logic [7:0] mp0,
    input logic [7:0] mp1
);
    logic hole;
    assign hole = (addr >= 8'h0F && addr <= 8'h11) || addr == 8'h1F || addr == 8'h20
               || (addr >= 8'h24 && addr <= 8'h2F);

    // R9
    rst_ptr_clear_chk: assert property (@(posedge clk)
        rst |=> (mp0 == 8'h00 && mp1 == 8'h00));

    // R4
    hole_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        hole |-> rdata == 8'h00);

    // R4
    hole_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
        ((wr_en || bit_en) && hole) |=> ($stable(mp0) && $stable(mp1)));

    // R3
    self_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((addr == 8'h00 && (mp0 == 8'h00 || mp0 == 8'h02)) ||
         (addr == 8'h02 && (mp1 == 8'h00 || mp1 == 8'h02))) |-> rdata == 8'h00);

    // R3
    self_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
        ((wr_en || bit_en) && addr == 8'h00 && mp0 == 8'h00) |=> $stable(mp0));

    // R2
    window_reads_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == 8'h00 && mp0 == 8'h03) |-> rdata == mp1);

    // R2
    ptr_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 8'h01) |=> mp0 == $past(wdata));

    // R6
    bit_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && bit_en && bit_val && addr == 8'h01)
        |=> mp0 == ($past(mp0) | (8'd1 << $past(bit_sel))));

    // R7
    bit_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && bit_en && !bit_val && addr == 8'h01)
        |=> mp0 == ($past(mp0) & ~(8'd1 << $past(bit_sel))));

    // R8
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bit_en && addr == 8'h03) |=> mp1 == $past(wdata));
endmodule

bind dmem_regfile dmem_regfile_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wdata   (wdata),
    .wr_en   (wr_en),
    .bit_en  (bit_en),
    .bit_val (bit_val),
    .bit_sel (bit_sel),
    .rdata   (rdata),
    .mp0     (mp0_q),
    .mp1     (mp1_q)
);

// File: tb/dmem_regfile_tb.sv
`timescale 1ns/1ps
module dmem_regfile_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] addr, wdata;
    logic       wr_en, bit_en, bit_val;
    logic [2:0] bit_sel;
    logic [7:0] rdata;

    int checks = 0;
    int fails  = 0;

    logic [7:0] m [256];
    bit         known [256];

    always #4 clk = ~clk;

    dmem_regfile u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .bit_en(bit_en), .bit_val(bit_val), .bit_sel(bit_sel), .rdata(rdata)
    );

    function automatic bit m_impl(int a);
        return a >= 48 || a == 1 || (a >= 3 && a <= 14) || (a >= 18 && a <= 30)
            || (a >= 33 && a <= 35);
    endfunction

    function automatic int m_ea(int a);
        if (a == 0) return int'(m[1]);
        if (a == 2) return int'(m[3]);
        return a;
    endfunction

    function automatic bit m_blk(int a);
        int e = m_ea(a);
        return (a == 0 || a == 2) && (e == 0 || e == 2);
    endfunction

    function automatic logic [7:0] m_read(int a);
        int e = m_ea(a);
        if (m_blk(a) || !m_impl(e)) return 8'h00;
        return m[e];
    endfunction

    function automatic string tag_for(int a);
        if (a == 0 || a == 2) return "R2/R3";
        if (a >= 48)          return "R1";
        if (m_impl(a))        return "R5";
        return "R4";
    endfunction

    task automatic check(bit ok, string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: addr=%02h rdata=%02h expected %02h", tag, addr, act, exp);
        end
    endtask

    // one cycle: drive, compare rdata with the model, clock, update model
    task automatic step(input logic [7:0] a, input logic [7:0] d, input bit w,
                        input bit b, input bit bv, input logic [2:0] bs, input string tag);
        logic [7:0] exp, nv;
        int e;
        addr = a; wdata = d; wr_en = w; bit_en = b; bit_val = bv; bit_sel = bs;
        #1;
        e   = m_ea(int'(a));
        exp = m_read(int'(a));
        if (m_blk(int'(a)) || !m_impl(e) || known[e])
            check(rdata === exp, tag, rdata, exp);
        nv = w ? d : (bv ? (m[e] | (8'd1 << bs)) : (m[e] & ~(8'd1 << bs)));
        @(posedge clk);
        if ((w || b) && !m_blk(int'(a)) && m_impl(e) && (w || known[e])) begin
            m[e] = nv;
            known[e] = 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(a, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
        step(a, d, 1'b1, 1'b0, 1'b0, 3'd0, tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        addr = 8'h00; wdata = 8'h00; wr_en = 0; bit_en = 0; bit_val = 0; bit_sel = 0;
        repeat (2) @(posedge clk);
        for (int i = 0; i < 48; i++) begin
            m[i] = 8'h00;
            known[i] = 1'b1;
        end
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            m[i] = 8'h00;
            known[i] = 1'b0;
        end
        do_reset();

        // R9 / R4 / R3: every low location after reset
        for (int a = 0; a < 48; a++) rd(8'(a), m_impl(a) ? "R9" : "R4");

        // R1: fill RAM, read some back
        for (int a = 48; a < 256; a++) wr(8'(a), 8'(a) ^ 8'h5A, "R1");
        rd(8'h30, "R1"); rd(8'hFF, "R1"); rd(8'h9C, "R1"); rd(8'h31, "R1");

        // R5: peripheral-style storage
        wr(8'h05, 8'h3C, "R5"); wr(8'h0A, 8'hC3, "R5"); wr(8'h04, 8'h01, "R5");
        wr(8'h1E, 8'h7E, "R5"); wr(8'h21, 8'h21, "R5"); wr(8'h23, 8'hE7, "R5");
        rd(8'h05, "R5"); rd(8'h0A, "R5"); rd(8'h04, "R5");
        rd(8'h1E, "R5"); rd(8'h21, "R5"); rd(8'h23, "R5");

        // R4: unused addresses ignore writes and bit ops
        wr(8'h0F, 8'hFF, "R4"); wr(8'h20, 8'hFF, "R4"); wr(8'h2F, 8'hFF, "R4");
        step(8'h24, 8'h00, 1'b0, 1'b1, 1'b1, 3'd3, "R4");
        rd(8'h0F, "R4"); rd(8'h20, "R4"); rd(8'h2F, "R4"); rd(8'h24, "R4");

        // R2: windows
        wr(8'h01, 8'h40, "R2"); rd(8'h00, "R2");
        wr(8'h00, 8'h99, "R2"); rd(8'h40, "R2");
        wr(8'h03, 8'h05, "R2"); rd(8'h02, "R2");
        wr(8'h03, 8'h01, "R2"); wr(8'h02, 8'h77, "R2"); rd(8'h01, "R2");
        wr(8'h01, 8'h03, "R2"); rd(8'h00, "R2");

        // R3: self-pointing windows
        wr(8'h01, 8'h00, "R3"); rd(8'h00, "R3");
        wr(8'h00, 8'h12, "R3"); rd(8'h01, "R3");
        wr(8'h01, 8'h02, "R3"); rd(8'h00, "R3");
        wr(8'h03, 8'h02, "R3"); wr(8'h02, 8'hAA, "R3"); rd(8'h03, "R3");
        step(8'h02, 8'h00, 1'b0, 1'b1, 1'b1, 3'd0, "R3"); rd(8'h03, "R3");
        wr(8'h03, 8'h00, "R3"); wr(8'h02, 8'h55, "R3"); rd(8'h01, "R3");

        // R6 / R7: bit operations, direct and through a window
        step(8'h05, 8'h00, 1'b0, 1'b1, 1'b1, 3'd7, "R6"); rd(8'h05, "R6");
        step(8'h05, 8'h00, 1'b0, 1'b1, 1'b0, 3'd2, "R7"); rd(8'h05, "R7");
        wr(8'h01, 8'h50, "R6");
        step(8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 3'd1, "R6"); rd(8'h50, "R6");
        step(8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 3'd4, "R7"); rd(8'h50, "R7");
        step(8'hC8, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, "R7"); rd(8'hC8, "R7");

        // R8: byte write wins over bit op
        step(8'h60, 8'h0F, 1'b1, 1'b1, 1'b1, 3'd7, "R8"); rd(8'h60, "R8");
        step(8'h60, 8'hF0, 1'b1, 1'b1, 1'b0, 3'd4, "R8"); rd(8'h60, "R8");

        // R9: reset clears SFRs, keeps RAM
        wr(8'h80, 8'h11, "R9");
        do_reset();
        rd(8'h80, "R9"); rd(8'h05, "R9"); rd(8'h01, "R9"); rd(8'h03, "R9"); rd(8'h04, "R9");

        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            logic [1:0] k;
            a = 8'($urandom);
            k = 2'($urandom);
            if ((n % 5) == 0) a = 8'($urandom_range(0, 3));
            step(a, 8'($urandom), k == 2'd1 || k == 2'd3, k[1], 1'($urandom),
                 3'($urandom), tag_for(int'(a)));
        end

        summary();
        $finish;
    end
endmodule